// File: doc/BRIEF.md
# Sector Cache Controller with Per-Subblock Status

This block is a direct-mapped, write-back cache controller in which each line has one tag shared by several subblocks. Every subblock keeps its own valid and dirty flag. A miss brings in only the subblock that holds the requested word, so memory traffic per miss is one subblock rather than a whole line. This saves memory bandwidth and tag storage, at the cost of more status bits and a greater reliance on spatial locality.

The processor side is a word port with byte enables. The processor holds a request until `cpu_ready` is high, and it is stalled while the controller moves data to or from memory. The memory side moves one subblock per transaction over a request/acknowledge handshake. When a miss needs a new tag, the dirty subblocks of the victim line are written back first. The new tag is then installed with every subblock invalid, and the requested subblock is fetched.

Top module: `sector_cache`

## Requirements
- R1: After reset every subblock of every line is invalid and clean, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: A read whose tag matches and whose subblock is valid returns the word with `cpu_ready` high in the same cycle, with no memory transaction.
- R3: With the default parameters, address bits [3:2] select the word, [5:4] the subblock, [8:6] the set and [31:9] the tag. A miss issues exactly one read transaction for the subblock holding the word, at an address with bits [3:0] zero, and the returned word comes from that fill.
- R4: A tag match with the subblock's valid flag clear fetches only that subblock. The tag, the other subblocks' data and their dirty flags are left unchanged, and nothing is written back.
- R5: When a miss installs a new tag, every other subblock of the line becomes invalid, so a later access to another subblock of the new tag misses.
- R6: Before a tag replacement, each dirty subblock of the victim line is written back once, one per transaction, in ascending subblock order, with the victim's tag in the address. Clean subblocks are not written.
- R7: A write miss first fetches the subblock, then merges the enabled bytes and marks that subblock dirty, so the merged data later reaches memory on eviction.
- R8: A write hit changes only the bytes whose enable bit is set. Bit i of `cpu_be` covers bits [8i+7:8i] of the word.
- R9: `cpu_ready` is never high while a memory transaction is pending or during write-back and fetch. It is high only for an access that hits, or in the single response cycle after a fill.
- R10: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = subblock write-back, 0 = subblock fetch |
| mem_addr | output | 32 | Subblock-aligned memory address |
| mem_wdata | output | 128 | Write-back subblock data |
| mem_rdata | input | 128 | Fetched subblock data, sampled with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge completing a transaction |

## Verification
The hardest case to reach is a tag replacement over a line that holds several dirty subblocks and also valid clean ones. This is where write-back ordering, invalidation and the data that survives all meet. The stimulus table first builds such lines through subblock misses and byte-enabled writes under one tag, then switches tags in the same set. The bench then reads the evicted words back after a second replacement, so the written-back data is checked against a model of memory, and the number and order of write-backs is counted per access.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE      = 2'd0,
      ST_WRITEBACK = 2'd1,
      ST_FETCH     = 2'd2,
      ST_RESPOND   = 2'd3
   } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
   parameter int SETS  = 8,
   parameter int NSUB  = 4,
   parameter int TAG_W = 23,
   localparam int SET_W  = $clog2(SETS),
   localparam int SSEL_W = $clog2(NSUB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  set_idx,
   input  logic              tag_we,
   input  logic [TAG_W-1:0]  tag_wdata,
   input  logic              fill_we,
   input  logic [SSEL_W-1:0] fill_sub,
   input  logic              mark_we,
   input  logic [SSEL_W-1:0] mark_sub,
   input  logic              clean_we,
   input  logic [SSEL_W-1:0] clean_sub,
   output logic [TAG_W-1:0]  line_tag,
   output logic [NSUB-1:0]   line_valid,
   output logic [NSUB-1:0]   line_dirty
);
   logic [TAG_W-1:0] tag_q   [SETS];
   logic [NSUB-1:0]  valid_q [SETS];
   logic [NSUB-1:0]  dirty_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tag_q[s]   <= '0;
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
      end else if (tag_we) begin
         tag_q[set_idx]   <= tag_wdata;
         valid_q[set_idx] <= '0;
         dirty_q[set_idx] <= '0;
      end else begin
         if (fill_we)  valid_q[set_idx][fill_sub]  <= 1'b1;
         if (mark_we)  dirty_q[set_idx][mark_sub]  <= 1'b1;
         if (clean_we) dirty_q[set_idx][clean_sub] <= 1'b0;
      end
   end

   assign line_tag   = tag_q[set_idx];
   assign line_valid = valid_q[set_idx];
   assign line_dirty = dirty_q[set_idx];
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
   parameter int SETS       = 8,
   parameter int NSUB       = 4,
   parameter int WPS        = 4,
   parameter int WORD_BYTES = 4,
   localparam int WORD_W = WORD_BYTES * 8,
   localparam int SUB_W  = WPS * WORD_W,
   localparam int SET_W  = $clog2(SETS),
   localparam int SSEL_W = $clog2(NSUB),
   localparam int WSEL_W = $clog2(WPS),
   localparam int WLG    = $clog2(WORD_W),
   localparam int BIT_W  = $clog2(SUB_W)
) (
   input  logic                  clk,
   input  logic [SET_W-1:0]      set_idx,
   input  logic [SSEL_W-1:0]     acc_sub,
   input  logic [WSEL_W-1:0]     acc_word,
   input  logic                  fill_we,
   input  logic [SUB_W-1:0]      fill_data,
   input  logic                  wr_en,
   input  logic [WORD_BYTES-1:0] wr_be,
   input  logic [WORD_W-1:0]     wr_data,
   input  logic [SSEL_W-1:0]     wb_sub,
   output logic [WORD_W-1:0]     rd_word,
   output logic [SUB_W-1:0]      wb_data
);
   logic [SUB_W-1:0] mem_q [SETS*NSUB];
   logic [BIT_W-1:0] word_base;

   assign word_base = {acc_word, {WLG{1'b0}}};

   always_ff @(posedge clk) begin
      if (fill_we) begin
         mem_q[{set_idx, acc_sub}] <= fill_data;
      end else if (wr_en) begin
         for (int b = 0; b < WORD_BYTES; b++) begin
            if (wr_be[b])
               mem_q[{set_idx, acc_sub}][word_base + BIT_W'(b*8) +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   assign rd_word = mem_q[{set_idx, acc_sub}][word_base +: WORD_W];
   assign wb_data = mem_q[{set_idx, wb_sub}];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
#(
   parameter int NSUB = 4,
   localparam int SSEL_W = $clog2(NSUB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              hit,
   input  logic              tag_hit,
   input  logic [NSUB-1:0]   line_dirty,
   input  logic              mem_ack,
   output sc_state_e         state,
   output logic [SSEL_W-1:0] wb_sub,
   output logic              tag_we,
   output logic              fill_we,
   output logic              wr_en,
   output logic              clean_we,
   output logic              mem_req,
   output logic              mem_we,
   output logic              cpu_ready
);
   sc_state_e       state_d;
   logic [NSUB-1:0] wb_onehot;
   logic            more_dirty;

   // lowest dirty subblock first: scan downward so the last hit wins
   always_comb begin
      wb_sub = '0;
      for (int i = NSUB - 1; i >= 0; i--)
         if (line_dirty[i]) wb_sub = SSEL_W'(i);
   end

   generate
      for (genvar g = 0; g < NSUB; g++) begin : g_onehot
         assign wb_onehot[g] = (wb_sub == SSEL_W'(g));
      end
   endgenerate

   assign more_dirty = |(line_dirty & ~wb_onehot);

   always_comb begin
      state_d   = state;
      tag_we    = 1'b0;
      fill_we   = 1'b0;
      wr_en     = 1'b0;
      clean_we  = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      cpu_ready = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (cpu_req && hit) begin
               cpu_ready = 1'b1;
               wr_en     = cpu_we;
            end else if (cpu_req) begin
               if (tag_hit) begin
                  state_d = ST_FETCH;
               end else if (|line_dirty) begin
                  state_d = ST_WRITEBACK;
               end else begin
                  tag_we  = 1'b1;
                  state_d = ST_FETCH;
               end
            end
         end
         ST_WRITEBACK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ack) begin
               clean_we = 1'b1;
               if (!more_dirty) begin
                  tag_we  = 1'b1;
                  state_d = ST_FETCH;
               end
            end
         end
         ST_FETCH: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               fill_we = 1'b1;
               state_d = ST_RESPOND;
            end
         end
         ST_RESPOND: begin
            cpu_ready = 1'b1;
            wr_en     = cpu_we;
            state_d   = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end
endmodule

// File: rtl/sector_cache.sv
module sector_cache
   import sc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int LINE_BYTES = 64,
   parameter int SUB_BYTES  = 16,
   parameter int SETS       = 8,
   localparam int WORD_W = WORD_BYTES * 8,
   localparam int SUB_W  = SUB_BYTES * 8,
   localparam int NSUB   = LINE_BYTES / SUB_BYTES,
   localparam int WPS    = SUB_BYTES / WORD_BYTES,
   localparam int BOFF_W = $clog2(WORD_BYTES),
   localparam int SOFF_W = $clog2(SUB_BYTES),
   localparam int SSEL_W = $clog2(NSUB),
   localparam int LOFF_W = $clog2(LINE_BYTES),
   localparam int SET_W  = $clog2(SETS),
   localparam int TAG_W  = ADDR_W - LOFF_W - SET_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_req,
   input  logic                  cpu_we,
   input  logic [ADDR_W-1:0]     cpu_addr,
   input  logic [WORD_BYTES-1:0] cpu_be,
   input  logic [WORD_W-1:0]     cpu_wdata,
   output logic [WORD_W-1:0]     cpu_rdata,
   output logic                  cpu_ready,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [SUB_W-1:0]      mem_wdata,
   input  logic [SUB_W-1:0]      mem_rdata,
   input  logic                  mem_ack
);
   generate
      if (SUB_BYTES % WORD_BYTES != 0 || LINE_BYTES % SUB_BYTES != 0) begin : g_bad_div
         $error("sector_cache: line, subblock and word sizes must divide evenly");
      end
      if ((SETS & (SETS - 1)) != 0 || (NSUB & (NSUB - 1)) != 0 || (WPS & (WPS - 1)) != 0) begin : g_bad_pow2
         $error("sector_cache: set, subblock and word counts must be powers of two");
      end
      if (SETS < 2 || NSUB < 2 || WPS < 2 || TAG_W < 1) begin : g_bad_size
         $error("sector_cache: need at least two sets, subblocks and words, and one tag bit");
      end
   endgenerate

   logic [SOFF_W-BOFF_W-1:0] req_word;
   logic [SSEL_W-1:0]        req_sub;
   logic [SET_W-1:0]         req_set;
   logic [TAG_W-1:0]         req_tag;

   assign req_word = cpu_addr[SOFF_W-1:BOFF_W];
   assign req_sub  = cpu_addr[LOFF_W-1:SOFF_W];
   assign req_set  = cpu_addr[LOFF_W+SET_W-1:LOFF_W];
   assign req_tag  = cpu_addr[ADDR_W-1:LOFF_W+SET_W];

   logic [TAG_W-1:0]  line_tag;
   logic [NSUB-1:0]   line_valid;
   logic [NSUB-1:0]   line_dirty;
   logic              tag_hit;
   logic              hit;
   sc_state_e         state;
   logic [SSEL_W-1:0] wb_sub;
   logic              tag_we;
   logic              fill_we;
   logic              wr_en;
   logic              clean_we;

   assign tag_hit = (|line_valid) && (line_tag == req_tag);
   assign hit     = tag_hit && line_valid[req_sub];

   sc_tag_store #(.SETS(SETS), .NSUB(NSUB), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_idx   (req_set),
      .tag_we    (tag_we),
      .tag_wdata (req_tag),
      .fill_we   (fill_we),
      .fill_sub  (req_sub),
      .mark_we   (wr_en && cpu_we),
      .mark_sub  (req_sub),
      .clean_we  (clean_we),
      .clean_sub (wb_sub),
      .line_tag  (line_tag),
      .line_valid(line_valid),
      .line_dirty(line_dirty)
   );

   sc_data_store #(.SETS(SETS), .NSUB(NSUB), .WPS(WPS), .WORD_BYTES(WORD_BYTES)) u_data (
      .clk      (clk),
      .set_idx  (req_set),
      .acc_sub  (req_sub),
      .acc_word (req_word),
      .fill_we  (fill_we),
      .fill_data(mem_rdata),
      .wr_en    (wr_en),
      .wr_be    (cpu_be),
      .wr_data  (cpu_wdata),
      .wb_sub   (wb_sub),
      .rd_word  (cpu_rdata),
      .wb_data  (mem_wdata)
   );

   sc_ctrl #(.NSUB(NSUB)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .hit       (hit),
      .tag_hit   (tag_hit),
      .line_dirty(line_dirty),
      .mem_ack   (mem_ack),
      .state     (state),
      .wb_sub    (wb_sub),
      .tag_we    (tag_we),
      .fill_we   (fill_we),
      .wr_en     (wr_en),
      .clean_we  (clean_we),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .cpu_ready (cpu_ready)
   );

   logic [TAG_W-1:0]  mem_tag;
   logic [SSEL_W-1:0] mem_sub;

   assign mem_tag  = (state == ST_WRITEBACK) ? line_tag : req_tag;
   assign mem_sub  = (state == ST_WRITEBACK) ? wb_sub : req_sub;
   assign mem_addr = {mem_tag, req_set, mem_sub, {SOFF_W{1'b0}}};
endmodule

// File: rtl/sc_checker.sv
module sc_checker
   import sc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SOFF_W = 4,
   parameter int SSEL_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input sc_state_e         state
);
   localparam int SUB_LO = SOFF_W;
   localparam int SUB_HI = SOFF_W + SSEL_W - 1;

   // R9: processor stalled while data moves
   a_r9_stall_during_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITEBACK || state == ST_FETCH) |-> !cpu_ready);

   // R9: completion only for a live request
   a_r9_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R10: request held stable until acknowledged
   a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R6: memory writes only as write-back of a victim line
   a_r6_write_only_in_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (state == ST_WRITEBACK));

   // R6: consecutive write-backs go to a higher subblock
   a_r6_wb_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ack && mem_req && mem_we) |=>
         (!(mem_req && mem_we) || (mem_addr[SUB_HI:SUB_LO] > $past(mem_addr[SUB_HI:SUB_LO]))));

   // R3: memory address is subblock aligned
   a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[SOFF_W-1:0] == '0));

   // R3: a fill is followed by the response cycle
   a_r3_fill_then_respond: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ack && mem_req && !mem_we) |=> cpu_ready);
endmodule

bind sector_cache sc_checker #(
   .ADDR_W(ADDR_W),
   .SOFF_W(SOFF_W),
   .SSEL_W(SSEL_W)
) u_sc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_ready(cpu_ready),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr),
   .state    (state)
);

// File: tb/test_sector_cache.sv
`timescale 1ns/1ps
module test_sector_cache;
   localparam int LAT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0;
   logic         cpu_we = 1'b0;
   logic [31:0]  cpu_addr = '0;
   logic [3:0]   cpu_be = '0;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ready;
   logic         mem_req;
   logic         mem_we;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [127:0] mem_rdata = '0;
   logic         mem_ack = 1'b0;

   always #2.5 clk = ~clk;

   sector_cache i_sector_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
   endfunction

   // memory model
   bit [127:0] memv [bit [31:0]];
   int tot_rd = 0, tot_wb = 0, asc_bad = 0, hs_bad = 0;
   int op_seq = 0, last_seq = -1;
   logic [31:0] last_wb = '0, p_addr = '0;
   logic p_we = 1'b0;
   bit pend = 0;
   int cnt = 0;

   function automatic logic [127:0] sub_val(input logic [31:0] a);
      logic [127:0] v;
      if (memv.exists(a)) return memv[a];
      for (int w = 0; w < 4; w++) v[w*32 +: 32] = pat(a + 32'(w*4));
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; cnt = 0; pend = 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0; cnt = 0; pend = 0;
      end else if (mem_req) begin
         if (pend && (mem_addr !== p_addr || mem_we !== p_we)) hs_bad++;
         pend = 1; p_addr = mem_addr; p_we = mem_we;
         if (cnt == LAT - 1) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               memv[mem_addr] = mem_wdata;
               tot_wb++;
               if (last_seq == op_seq && mem_addr <= last_wb) asc_bad++;
               last_seq = op_seq; last_wb = mem_addr;
            end else begin
               mem_rdata <= sub_val(mem_addr);
               tot_rd++;
            end
         end else cnt++;
      end
   end

   // processor-view reference
   bit [31:0] gold [bit [31:0]];

   function automatic logic [31:0] gold_rd(input logic [31:0] a);
      logic [31:0] wa = {a[31:2], 2'b00};
      return gold.exists(wa) ? gold[wa] : pat(wa);
   endfunction

   int op_rd, op_wb, op_wait;
   bit op_stall_bad, op_asc_bad;

   task automatic do_op(input logic we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd);
      int r0, w0, s0;
      logic [31:0] cur;
      @(negedge clk);
      op_seq++;
      r0 = tot_rd; w0 = tot_wb; s0 = asc_bad;
      op_wait = 0; op_stall_bad = 0;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
      forever begin
         #1;
         if (cpu_ready && mem_req) op_stall_bad = 1;
         if (cpu_ready) break;
         op_wait++;
         @(negedge clk);
      end
      rd = cpu_rdata;
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      op_rd = tot_rd - r0; op_wb = tot_wb - w0; op_asc_bad = (asc_bad != s0);
      if (we) begin
         cur = gold_rd(a);
         for (int b = 0; b < 4; b++) if (be[b]) cur[b*8 +: 8] = wd[b*8 +: 8];
         gold[{a[31:2], 2'b00}] = cur;
      end
   endtask

   typedef struct packed {
      logic        we;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [1:0]  exp_rd;
      logic [2:0]  exp_wb;
   } vec_t;

   // set 1 tags: A=0x040 base, B=0x240 base, C=0x440 base
   localparam vec_t VECS [17] = '{
      '{1'b0, 32'h044, 4'h0, 32'h0,          2'd1, 3'd0}, // R1 R3 cold miss
      '{1'b0, 32'h048, 4'h0, 32'h0,          2'd0, 3'd0}, // R2 hit
      '{1'b1, 32'h058, 4'hF, 32'h1111_2222,  2'd1, 3'd0}, // R4 R7 write subblock miss
      '{1'b1, 32'h040, 4'h3, 32'hAAAA_BBBB,  2'd0, 3'd0}, // R8 partial write hit
      '{1'b0, 32'h040, 4'h0, 32'h0,          2'd0, 3'd0}, // R8 merged readback
      '{1'b0, 32'h070, 4'h0, 32'h0,          2'd1, 3'd0}, // R4 subblock miss, no write-back
      '{1'b0, 32'h058, 4'h0, 32'h0,          2'd0, 3'd0}, // R4 other subblock kept
      '{1'b0, 32'h244, 4'h0, 32'h0,          2'd1, 3'd2}, // R6 two dirty written back
      '{1'b0, 32'h040, 4'h0, 32'h0,          2'd1, 3'd0}, // R5 replace clean line
      '{1'b0, 32'h058, 4'h0, 32'h0,          2'd1, 3'd0}, // R5 R7 invalid after replace
      '{1'b1, 32'h27C, 4'h8, 32'hCC00_0000,  2'd1, 3'd0}, // R7 write miss, clean victim
      '{1'b1, 32'h264, 4'h4, 32'h00DD_0000,  2'd1, 3'd0}, // R4 R7 write subblock miss
      '{1'b0, 32'h444, 4'h0, 32'h0,          2'd1, 3'd2}, // R6 subblocks 2 then 3
      '{1'b0, 32'h27C, 4'h0, 32'h0,          2'd1, 3'd0}, // R7 merged data from memory
      '{1'b0, 32'h084, 4'h0, 32'h0,          2'd1, 3'd0}, // R3 other set
      '{1'b0, 32'h27C, 4'h0, 32'h0,          2'd0, 3'd0}, // R2 set 1 untouched
      '{1'b0, 32'h264, 4'h0, 32'h0,          2'd1, 3'd0}  // R5 R7 subblock miss
   };

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cpu_ready == 1'b0, "R1 cpu_ready low after reset", 32'(cpu_ready), 32'd0);
      check(mem_req == 1'b0, "R1 mem_req low after reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;

      foreach (VECS[i]) begin
         do_op(VECS[i].we, VECS[i].addr, VECS[i].be, VECS[i].wdata, rd);
         check(op_rd == int'(VECS[i].exp_rd), $sformatf("R1/R3/R4/R5 fetch count, vector %0d", i),
               32'(op_rd), 32'(VECS[i].exp_rd));
         check(op_wb == int'(VECS[i].exp_wb), $sformatf("R4/R6 write-back count, vector %0d", i),
               32'(op_wb), 32'(VECS[i].exp_wb));
         check(!op_asc_bad, $sformatf("R6 ascending write-back order, vector %0d", i), 32'(op_asc_bad), 32'd0);
         check(!op_stall_bad, $sformatf("R9 ready during transfer, vector %0d", i), 32'(op_stall_bad), 32'd0);
         if (VECS[i].exp_rd != 0)
            check(op_wait >= LAT, $sformatf("R9 stalled across miss, vector %0d", i), 32'(op_wait), 32'(LAT));
         else
            check(op_wait == 0, $sformatf("R2 same-cycle completion, vector %0d", i), 32'(op_wait), 32'd0);
         if (!VECS[i].we)
            check(rd == gold_rd(VECS[i].addr), $sformatf("R2/R3/R7/R8 read data, vector %0d", i),
                  rd, gold_rd(VECS[i].addr));
      end

      // R10: handshake stability seen by the memory model
      check(hs_bad == 0, "R10 request held stable", 32'(hs_bad), 32'd0);

      // R1: reset again drops all valid bits; a previous hit now misses
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(cpu_ready == 1'b0 && mem_req == 1'b0, "R1 outputs idle in reset", {cpu_ready, mem_req}, 32'd0);
      rst_n = 1'b1;
      do_op(1'b0, 32'h27C, 4'h0, 32'h0, rd);
      check(op_rd == 1, "R1 miss after reset", 32'(op_rd), 32'd1);
      check(op_wb == 0, "R1 clean after reset", 32'(op_wb), 32'd0);
      check(rd == gold_rd(32'h27C), "R1/R7 data after reset", rd, gold_rd(32'h27C));

      // R8: zero byte enables leave the word unchanged
      do_op(1'b1, 32'h27C, 4'h0, 32'hFFFF_FFFF, rd);
      do_op(1'b0, 32'h27C, 4'h0, 32'h0, rd);
      check(rd == gold_rd(32'h27C), "R8 no-enable write has no effect", rd, gold_rd(32'h27C));

      finished = 1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         summary();
      end
   end
endmodule